// File: doc/BRIEF.md
# Register-Value Bypass Cache

This block is a small, fully associative store of recently produced results. It sits between the result path and the issue side of a pipeline whose stages are decoupled, so there are no forwarding wires between them. Each entry pairs a destination register number with its value. When a result is written, it lands in an entry. When an instruction is issued, it presents its two source register numbers and gets back, for each one, a hit flag and the stored value. On a hit the operand can be used at once, with no wait for the register file and no transfer over the links between stages.

Any entry can hold any register. A register that is already present is updated where it sits. A register that is not present takes the entry chosen by a first-in-first-out pointer, which replaces the entry allocated longest ago. Register zero is never stored. A flush empties the store and returns the pointer to its start. A result written in the same cycle as a lookup of that register is passed straight to the lookup.

Top module: `bypass_cache`

## Requirements
- R1: After reset, every lookup on both ports reports a miss (hit low).
- R2: A write of value V to register R (R not zero, no flush in that cycle) makes every later lookup of R report hit high and value V, until R is overwritten, evicted or flushed.
- R3: A lookup of a register that has not been written since reset or the last flush reports a miss.
- R4: When a write to register R (R not zero, no flush) and a lookup of R occur in the same cycle, the lookup reports hit high and the value being written, in that same cycle.
- R5: A write to register zero stores nothing, and a lookup of register zero always reports a miss.
- R6: A write to a register that is already held updates that entry in place. It takes no new entry, so at most one valid entry ever matches a register, and the lookup returns the newest value.
- R7: With all DEPTH entries holding distinct registers, a write of a new register replaces the register that was allocated earliest. In-place updates do not count as allocations. All other registers keep their values.
- R8: A flush makes all lookups miss from the next cycle onward. It also restarts allocation, so after a flush the first register allocated is the first one evicted once DEPTH more allocations follow.
- R9: In a cycle with flush high, a concurrent write is dropped and both lookups report a miss.
- R10: The two lookup ports are independent: each reports the hit and value for its own register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush | input | 1 | Invalidate all entries and restart allocation |
| wr_en | input | 1 | Result write strobe |
| wr_reg | input | $clog2(NREG) | Destination register of the result |
| wr_data | input | DW | Result value |
| rd_reg_a | input | $clog2(NREG) | Source register, port A |
| hit_a | output | 1 | Port A found a valid copy |
| val_a | output | DW | Port A value (valid when hit_a) |
| rd_reg_b | input | $clog2(NREG) | Source register, port B |
| hit_b | output | 1 | Port B found a valid copy |
| val_b | output | DW | Port B value (valid when hit_b) |

## Verification
The pointer order is the hardest thing to reach from the ports, because it is visible only through which register vanishes after the store fills. To get there, the stimulus fills all entries, then mixes in-place rewrites of the oldest register with fresh allocations, and looks up every register after each step to see which one was lost. A flush issued while the pointer is mid-way through the entries, followed by DEPTH+1 fresh allocations, shows that allocation restarts from the beginning after a flush.

// File: rtl/bypass_cache.sv
module bypass_cache #(
  parameter int DEPTH = 8,
  parameter int NREG  = 32,
  parameter int DW    = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_reg,
  input  logic [DW-1:0]           wr_data,
  input  logic [$clog2(NREG)-1:0] rd_reg_a,
  output logic                    hit_a,
  output logic [DW-1:0]           val_a,
  input  logic [$clog2(NREG)-1:0] rd_reg_b,
  output logic                    hit_b,
  output logic [DW-1:0]           val_b
);
  localparam int RW = $clog2(NREG);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0] vld;
  logic [RW-1:0]    tag [DEPTH];
  logic [DW-1:0]    dat [DEPTH];
  logic [PW-1:0]    ptr;

  logic [DEPTH-1:0] wm, am, bm;
  logic             wr_go, wr_in;
  logic [PW-1:0]    widx;

  for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
    assign wm[i] = vld[i] && tag[i] == wr_reg;
    assign am[i] = vld[i] && tag[i] == rd_reg_a;
    assign bm[i] = vld[i] && tag[i] == rd_reg_b;
  end

  assign wr_go = wr_en && wr_reg != '0 && !flush;
  assign wr_in = |wm;

  always_comb begin
    widx = '0;
    for (int i = 0; i < DEPTH; i++)
      if (wm[i]) widx = PW'(i);
  end

  function automatic logic [DW-1:0] pick(input logic [DEPTH-1:0] m);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < DEPTH; i++)
      if (m[i]) v = dat[i];
    return v;
  endfunction

  logic fwd_a, fwd_b;
  assign fwd_a = wr_go && wr_reg == rd_reg_a;
  assign fwd_b = wr_go && wr_reg == rd_reg_b;

  assign hit_a = !flush && rd_reg_a != '0 && (fwd_a || |am);
  assign hit_b = !flush && rd_reg_b != '0 && (fwd_b || |bm);
  assign val_a = fwd_a ? wr_data : pick(am);
  assign val_b = fwd_b ? wr_data : pick(bm);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld <= '0;
      ptr <= '0;
    end else if (flush) begin
      vld <= '0;
      ptr <= '0;
    end else if (wr_go && !wr_in) begin
      vld[ptr] <= 1'b1;
      ptr      <= (ptr == PW'(DEPTH-1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_go) begin
      if (wr_in) begin
        dat[widx] <= wr_data;
      end else begin
        tag[ptr] <= wr_reg;
        dat[ptr] <= wr_data;
      end
    end
  end

  p_zero_miss_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_reg_a == '0 |-> !hit_a);

  p_one_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(am) <= 1);

  p_same_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !flush && wr_reg != '0 && rd_reg_b == wr_reg) |-> (hit_b && val_b == wr_data));

  p_flush_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (vld == '0 && ptr == '0));

  p_flush_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!hit_a && !hit_b));

  p_update_no_alloc_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && wr_en && wr_in) |=> $stable(ptr));
endmodule

// File: tb/sim_bypass_cache.sv
module sim_bypass_cache;
  localparam int DEPTH = 8;
  localparam int NREG  = 32;
  localparam int DW    = 32;
  localparam int RW    = $clog2(NREG);

  logic clk = 0, rst_n = 0, flush = 0, wr_en = 0;
  logic [RW-1:0] wr_reg = '0, rd_reg_a = '0, rd_reg_b = '0;
  logic [DW-1:0] wr_data = '0;
  logic hit_a, hit_b;
  logic [DW-1:0] val_a, val_b;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  bypass_cache #(.DEPTH(DEPTH), .NREG(NREG), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .wr_en(wr_en), .wr_reg(wr_reg),
    .wr_data(wr_data), .rd_reg_a(rd_reg_a), .hit_a(hit_a), .val_a(val_a),
    .rd_reg_b(rd_reg_b), .hit_b(hit_b), .val_b(val_b));

  task automatic chk(input string req, input logic [DW:0] act, input logic [DW:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int r, input logic [DW-1:0] v);
    @(negedge clk);
    wr_en = 1; wr_reg = RW'(r); wr_data = v;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic look(input string req, input int ra, input bit eh, input logic [DW-1:0] ev);
    @(negedge clk);
    rd_reg_a = RW'(ra); rd_reg_b = RW'(ra);
    #1;
    chk(req, {hit_a, eh ? val_a : '0}, {eh, eh ? ev : '0});
    chk(req, {hit_b, eh ? val_b : '0}, {eh, eh ? ev : '0});
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(posedge clk); #1; flush = 0;
  endtask

  task automatic t_reset_r1();
    for (int r = 0; r < NREG; r++) look("R1", r, 0, '0);
  endtask

  task automatic t_basic_r2_r3();
    wr(5, 32'hA5A5_0005);
    look("R2", 5, 1, 32'hA5A5_0005);
    look("R3", 6, 0, '0);
  endtask

  task automatic t_fwd_r4();
    @(negedge clk);
    wr_en = 1; wr_reg = 7; wr_data = 32'h0000_7777; rd_reg_a = 7; rd_reg_b = 5;
    #1;
    chk("R4", {hit_a, val_a}, {1'b1, 32'h0000_7777});
    chk("R10", {hit_b, val_b}, {1'b1, 32'hA5A5_0005});
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic t_zero_r5();
    wr(0, 32'hDEAD_0000);
    look("R5", 0, 0, '0);
    @(negedge clk);
    wr_en = 1; wr_reg = 0; rd_reg_a = 0; rd_reg_b = 0; #1;
    chk("R5", {hit_a, hit_b}, 2'b00);
    @(posedge clk); #1; wr_en = 0;
  endtask

  task automatic t_fifo_r6_r7();
    do_flush();
    for (int r = 1; r <= DEPTH; r++) wr(r, 32'h100 + r);
    for (int k = 0; k < 3; k++) wr(1, 32'h900 + k);
    look("R6", 1, 1, 32'h902);
    for (int r = 2; r <= DEPTH; r++) look("R6", r, 1, 32'h100 + r);
    wr(20, 32'h2020);
    look("R7", 1, 0, '0);
    look("R7", 20, 1, 32'h2020);
    for (int r = 2; r <= DEPTH; r++) look("R7", r, 1, 32'h100 + r);
    wr(21, 32'h2121);
    look("R7", 2, 0, '0);
    look("R7", 3, 1, 32'h103);
  endtask

  task automatic t_flush_r8_r9();
    look("R8", 3, 1, 32'h103);
    do_flush();
    for (int r = 1; r < NREG; r++) look("R8", r, 0, '0);
    for (int r = 10; r < 10 + DEPTH + 1; r++) wr(r, 32'h500 + r);
    look("R8", 10, 0, '0);
    look("R8", 11, 1, 32'h50B);
    @(negedge clk);
    flush = 1; wr_en = 1; wr_reg = 25; wr_data = 32'h25; rd_reg_a = 25; rd_reg_b = 12; #1;
    chk("R9", {hit_a, hit_b}, 2'b00);
    @(posedge clk); #1; flush = 0; wr_en = 0;
    look("R9", 25, 0, '0);
    look("R9", 12, 0, '0);
  endtask

  task automatic t_ports_r10();
    wr(3, 32'h33); wr(4, 32'h44);
    @(negedge clk);
    rd_reg_a = 3; rd_reg_b = 4; #1;
    chk("R10", {hit_a, val_a}, {1'b1, 32'h33});
    chk("R10", {hit_b, val_b}, {1'b1, 32'h44});
    rd_reg_b = 9; #1;
    chk("R10", {hit_b, hit_a}, 2'b01);
  endtask

  initial begin
    #1;
    t_reset_r1();
    @(negedge clk); rst_n = 1;
    t_reset_r1();
    t_basic_r2_r3();
    t_fwd_r4();
    t_zero_r5();
    t_fifo_r6_r7();
    t_flush_r8_r9();
    t_ports_r10();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule